// File: doc/BRIEF.md
# Banked Word Memory with Chip-Select Decoding

This block is a 16-bit word memory built from four byte-wide storage banks. Each bank holds 4K bytes. Two banks sit side by side to make one word: one holds the high byte and the other holds the low byte. Two such pairs are stacked to double the depth. The lower address bits go to every bank unchanged. The top address bit picks which pair is active, so the lower pair covers word addresses 0000H to 0FFFH and the upper pair covers 1000H to 1FFFH.

A single enable and a single read/write control serve all four banks. Every access therefore moves a whole word.
- Writes take effect at the clock edge.
- Reads return data one cycle after the request.

The read multiplexer uses a registered copy of the pair-select bit taken in the request cycle. Read data stays unchanged through write cycles and through cycles with the enable low. The decoded four-bit chip-select vector is a port, so the decode can be observed directly.

Top module: `banked_word_mem`

## Requirements
- R1: While reset is asserted and after it is released, `rdata` is 0 until the first enabled read completes.
- R2: With `en` low, every bit of `cs` is 0.
- R3: With `en` high, `cs` is 4'b0011 when the top address bit is 0 and 4'b1100 when it is 1. Bit 0 is bank A (high byte, lower half), bit 1 is bank B (low byte, lower half), bit 2 is bank C (high byte, upper half) and bit 3 is bank D (low byte, upper half).
- R4: `wdata[15:8]` is stored in the high-byte bank of the selected pair and `wdata[7:0]` in its low-byte bank. A read reassembles the word in the same lane order.
- R5: A word is written at the clock edge when `en` and `we` are both high. Only banks whose chip select is active are written.
- R6: The two halves are separate storage. A word address with the top bit clear and the same address with the top bit set hold independent values.
- R7: A read requested with `en` high and `we` low presents the addressed word on `rdata` after the next rising edge. The half is chosen from the address of the request cycle, even if the address changes afterwards.
- R8: With `en` low, nothing is written and `rdata` holds its previous value.
- R9: During a write cycle, `rdata` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Global access enable |
| we | input | 1 | 1 = write, 0 = read, shared by all banks |
| addr | input | 13 | Word address; bit 12 selects the half |
| wdata | input | 16 | Write data word |
| rdata | output | 16 | Read data word, one cycle after the request |
| cs | output | 4 | Decoded bank chip selects {D, C, B, A} |

## Verification
The bench builds the block with `BANK_AW` = 5, so each bank has 32 entries and the half-select bit is address bit 5. The whole 64-word space can then be filled directly and revisited thousands of times by random traffic. Random addresses often hit the same location in both halves, which exercises the separation of the halves. They also often cross the half boundary between back-to-back reads, which exposes a read multiplexer that follows the live address instead of the registered one.

// File: rtl/banked_word_mem_pkg.sv
package banked_word_mem_pkg;

  // Byte lane position inside a word: the high lane is index 0.
  typedef enum logic {
    LANE_HI = 1'b0,
    LANE_LO = 1'b1
  } lane_e;

  // Flat bank index from half (row) and lane: A=0, B=1, C=2, D=3.
  function automatic int bank_index(input int row, input int lane, input int lanes);
    return row * lanes + lane;
  endfunction

  // Least significant data bit carried by a lane.
  function automatic int lane_lsb(input int lane, input int lanes, input int lane_w);
    return (lanes - 1 - lane) * lane_w;
  endfunction

endpackage

// File: rtl/bank_sel_decode.sv
module bank_sel_decode
  import banked_word_mem_pkg::*;
#(
  parameter int ROWS   = 2,
  parameter int LANES  = 2,
  localparam int NB    = ROWS * LANES,
  localparam int RSEL_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              en,
  input  logic [RSEL_W-1:0] row,
  output logic [NB-1:0]     cs
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign cs[bank_index(r, l, LANES)] = en && (row == RSEL_W'(r));
    end
  end

endmodule

// File: rtl/bank_ram.sv
module bank_ram #(
  parameter int AW = 12,
  parameter int W  = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] a,
  input  logic [W-1:0]  d,
  output logic [W-1:0]  q
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[a] <= d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (rd) q <= mem[a];
  end

endmodule

// File: rtl/rd_lane_mux.sv
module rd_lane_mux
  import banked_word_mem_pkg::*;
#(
  parameter int ROWS   = 2,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int NB     = ROWS * LANES,
  localparam int DW     = LANES * LANE_W,
  localparam int RSEL_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic [RSEL_W-1:0]         row_q,
  input  logic [NB-1:0][LANE_W-1:0] bank_q,
  output logic [DW-1:0]             word
);

  always_comb begin
    word = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (row_q == RSEL_W'(r)) begin
        for (int l = 0; l < LANES; l++) begin
          word[lane_lsb(l, LANES, LANE_W) +: LANE_W] = bank_q[bank_index(r, l, LANES)];
        end
      end
    end
  end

endmodule

// File: rtl/banked_word_mem.sv
module banked_word_mem
  import banked_word_mem_pkg::*;
#(
  parameter int BANK_AW = 12,
  parameter int LANE_W  = 8,
  parameter int LANES   = 2,
  parameter int ROWS    = 2,
  localparam int NB     = ROWS * LANES,
  localparam int DATA_W = LANES * LANE_W,
  localparam int RSEL_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int ADDR_W = BANK_AW + RSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NB-1:0]     cs
);

  logic [RSEL_W-1:0]         row_sel;
  logic [RSEL_W-1:0]         row_q;
  logic [BANK_AW-1:0]        bank_addr;
  logic [NB-1:0]             bank_wr;
  logic [NB-1:0]             bank_rd;
  logic [NB-1:0][LANE_W-1:0] bank_q;
  logic                      rd_req;

  assign row_sel   = addr[ADDR_W-1 -: RSEL_W];
  assign bank_addr = addr[BANK_AW-1:0];
  assign rd_req    = en && !we;

  bank_sel_decode #(.ROWS(ROWS), .LANES(LANES)) u_dec (
    .en  (en),
    .row (row_sel),
    .cs  (cs)
  );

  assign bank_wr = we ? cs : '0;
  assign bank_rd = we ? '0 : cs;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int IDX = bank_index(r, l, LANES);
      localparam int LSB = lane_lsb(l, LANES, LANE_W);
      bank_ram #(.AW(BANK_AW), .W(LANE_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bank_wr[IDX]),
        .rd    (bank_rd[IDX]),
        .a     (bank_addr),
        .d     (wdata[LSB +: LANE_W]),
        .q     (bank_q[IDX])
      );
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (rd_req) row_q <= row_sel;
  end

  rd_lane_mux #(.ROWS(ROWS), .LANES(LANES), .LANE_W(LANE_W)) u_mux (
    .row_q  (row_q),
    .bank_q (bank_q),
    .word   (rdata)
  );

endmodule

// File: rtl/banked_word_mem_chk.sv
module banked_word_mem_chk #(
  parameter int NB = 4,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          we,
  input logic          row_bit,
  input logic [NB-1:0] cs,
  input logic [NB-1:0] bank_wr,
  input logic [DW-1:0] rdata
);

  // R2
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (cs == '0));

  // R3
  cs_lower_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !row_bit) |-> ((&cs[NB/2-1:0]) && !(|cs[NB-1:NB/2])));

  // R3
  cs_upper_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && row_bit) |-> ((&cs[NB-1:NB/2]) && !(|cs[NB/2-1:0])));

  // R5
  wr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr != '0) |-> (en && we && ((bank_wr & ~cs) == '0)));

  // R8
  rd_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rdata));

  // R9
  rd_hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && we) |=> $stable(rdata));

endmodule

bind banked_word_mem banked_word_mem_chk #(.NB(NB), .DW(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .we      (we),
  .row_bit (addr[ADDR_W-1]),
  .cs      (cs),
  .bank_wr (bank_wr),
  .rdata   (rdata)
);

// File: tb/sim_banked_word_mem.sv
module sim_banked_word_mem;

  localparam int CLK_PERIOD = 10;
  localparam int BANK_AW = 5;
  localparam int ADDR_W  = BANK_AW + 1;
  localparam int WORDS   = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       wdata = '0;
  logic [15:0]       rdata;
  logic [3:0]        cs;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] model [WORDS];
  logic [15:0] exp_rd = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_word_mem #(.BANK_AW(BANK_AW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cs(cs)
  );

  function automatic logic [3:0] exp_cs(input logic e, input logic [ADDR_W-1:0] a);
    if (!e) return 4'b0000;
    return a[ADDR_W-1] ? 4'b1100 : 4'b0011;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Each call: check result of the previous edge, drive, check decode, update model.
  task automatic op(input logic e, input logic w, input logic [ADDR_W-1:0] a,
                    input logic [15:0] d, input string tag);
    @(negedge clk);
    chk(rdata === exp_rd, tag, rdata, exp_rd);
    en = e; we = w; addr = a; wdata = d;
    #1;
    chk(cs === exp_cs(e, a), (e ? "R3" : "R2"), {12'h0, cs}, {12'h0, exp_cs(e, a)});
    if (e && w)  model[a] = d;
    if (e && !w) exp_rd = model[a];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rdata === 16'h0, "R1", rdata, 16'h0);
    chk(cs === 4'b0000, "R2", {12'h0, cs}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdata === 16'h0, "R1", rdata, 16'h0);

    // R4 R5: fill every word with a distinct pattern
    for (int i = 0; i < WORDS; i++) op(1'b1, 1'b1, ADDR_W'(i), 16'hA500 ^ 16'(i * 16'h0111), "R5");
    // R7: read back across both halves, alternating halves
    for (int i = 0; i < WORDS / 2; i++) begin
      op(1'b1, 1'b0, ADDR_W'(i), 16'h0, "R7");
      op(1'b1, 1'b0, ADDR_W'(i + WORDS / 2), 16'h0, "R7");
    end
    // R4: lane order with asymmetric bytes
    op(1'b1, 1'b1, ADDR_W'(0), 16'h12EF, "R4");
    op(1'b1, 1'b0, ADDR_W'(0), 16'h0, "R4");
    // R6: same offset in both halves holds separate values
    op(1'b1, 1'b1, ADDR_W'(WORDS/2 - 1), 16'h1111, "R6");
    op(1'b1, 1'b1, ADDR_W'(WORDS - 1), 16'h2222, "R6");
    op(1'b1, 1'b0, ADDR_W'(WORDS/2 - 1), 16'h0, "R6");
    op(1'b1, 1'b0, ADDR_W'(WORDS - 1), 16'h0, "R6");
    // R8: disabled write leaves memory alone, disabled cycles hold rdata
    op(1'b0, 1'b1, ADDR_W'(WORDS/2), 16'hDEAD, "R8");
    op(1'b0, 1'b0, ADDR_W'(3), 16'h0, "R8");
    op(1'b1, 1'b0, ADDR_W'(WORDS/2), 16'h0, "R8");
    op(1'b0, 1'b0, ADDR_W'(0), 16'h0, "R8");
    // R9: write cycle keeps rdata
    op(1'b1, 1'b1, ADDR_W'(5), 16'hBEEF, "R9");
    op(1'b1, 1'b1, ADDR_W'(WORDS - 2), 16'hCAFE, "R9");
    op(1'b1, 1'b0, ADDR_W'(5), 16'h0, "R9");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic e, w;
      e = ($urandom % 8) != 0;
      w = $urandom % 2;
      op(e, w, ADDR_W'($urandom), 16'($urandom), e ? (w ? "R5" : "R7") : "R8");
    end
    op(1'b0, 1'b0, '0, 16'h0, "R8");
    @(negedge clk);
    chk(rdata === exp_rd, "R8", rdata, exp_rd);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule